// File: doc/BRIEF.md
# Virtual Disk Sector Transfer Client

This block sits on the core side of a virtual disk link. Core logic asks it to move one or more fixed-size blocks of a mounted disk image to or from a local sector buffer. The client checks each request against what it knows about the target drive. It then raises a per-drive read or write request line toward the host, together with the block address and block count. After that it follows the host's acknowledge window until the transfer completes. Inside that window the host steps a byte address at up to one byte per clock and there is no way to stall it. For this reason incoming bytes go straight into a dual-port buffer. For outgoing bytes, the buffer returns the byte at the host's address one clock later.

The block size is set by a 3-bit code, giving 128 bytes shifted left by the code. The count input carries the number of blocks minus one. The client also keeps, for each drive, the read-only flag and the 64-bit image size that the host announces with a one-cycle mount pulse. A size of zero means the image was removed. The core reaches the other port of the buffer with a plain address, write enable and registered read data.

Top module: `vdx_xfer_client`

## Requirements
- R1: The transfer length is (req_cnt + 1) * (128 << BLK_CODE) bytes. A request whose length exceeds the buffer (2^BUF_AW bytes) or 16384 bytes is refused.
- R2: When req_valid is high, busy is low and every hst_ack bit is low, an acceptable request is taken at that edge. From the next cycle: busy is high; exactly one request line is high (hst_rd[req_drive] when req_write=0, hst_wr[req_drive] when req_write=1); hst_lba and hst_cnt show the request's values.
- R3: The request line drops in the cycle after hst_ack of the active drive is sampled high.
- R4: After acknowledge is seen high, the first edge that samples it low makes done high for exactly one cycle, with busy low in that same cycle.
- R5: During a read, each edge with hst_wstb high and the active drive's hst_ack high stores hst_dout at hst_addr. core_rdata shows the byte at core_addr one cycle after the address is presented.
- R6: During a write, hst_din shows the buffer byte at hst_addr one cycle after the address is presented. hst_wstb has no effect on the buffer during a write.
- R7: A high img_mnt[i] latches img_ro and img_size for drive i. From the next cycle drv_ro[i] equals the flag, drv_size[64*i +: 64] equals the size, and drv_mounted[i] is high exactly when the size is nonzero.
- R8: A request to a drive that is not mounted or out of range, a write to a read-only drive, or an over-long request (R1) gives err high for one cycle starting in the next cycle. In that case no request line rises and busy stays low.
- R9: req_valid is ignored while busy is high or while any hst_ack bit is high. In that case hst_lba, hst_cnt and the request lines do not change and err stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request strobe |
| req_write | input | 1 | 1 = write to disk, 0 = read from disk |
| req_drive | input | DRV_W | Target drive index |
| req_lba | input | 32 | Starting logical block address |
| req_cnt | input | 6 | Number of blocks minus one |
| busy | output | 1 | Request pending or transfer open |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| core_addr | input | BUF_AW | Core buffer address |
| core_we | input | 1 | Core buffer write enable |
| core_wdata | input | 8 | Core buffer write data |
| core_rdata | output | 8 | Core buffer read data, one cycle latency |
| hst_rd | output | NDRV | Per-drive read request lines |
| hst_wr | output | NDRV | Per-drive write request lines |
| hst_lba | output | 32 | Latched block address |
| hst_cnt | output | 6 | Latched block count minus one |
| hst_ack | input | NDRV | Per-drive acknowledge window |
| hst_addr | input | BUF_AW | Host byte address |
| hst_wstb | input | 1 | Host byte strobe for reads |
| hst_dout | input | 8 | Byte from disk |
| hst_din | output | 8 | Byte to disk, one cycle latency |
| img_mnt | input | NDRV | Mount event pulse per drive |
| img_ro | input | 1 | Read-only flag for the event |
| img_size | input | 64 | Image size in bytes for the event |
| drv_mounted | output | NDRV | Drive holds a nonzero-size image |
| drv_ro | output | NDRV | Latched read-only flag |
| drv_size | output | NDRV*64 | Latched sizes, drive i at bits 64*i upward |

## Verification
Request lines, busy, err and the mount outputs change at the edge that samples the stimulus, so the bench drives inputs on the falling edge and reads them at the next falling edge. A dropped request after acknowledge rises, and the done pulse after acknowledge falls, are each checked one falling edge after the acknowledge change. The fact that done lasts a single cycle is checked at the falling edge after that. Both buffer ports have one cycle of read latency. The bench therefore compares hst_din and core_rdata against the address it set one falling edge earlier, and checks a whole block against patterns computed from drive, count and address.

// File: rtl/vdx_pkg.sv
package vdx_pkg;
    localparam int LBA_W          = 32;
    localparam int CNT_W          = 6;
    localparam int SIZE_W         = 64;
    localparam int XFER_LIMIT     = 16384;
    localparam int BLK_BASE_SHIFT = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/vdx_mount_track.sv
module vdx_mount_track
    import vdx_pkg::*;
#(
    parameter int NDRV = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NDRV-1:0]          img_mnt,
    input  logic                     img_ro,
    input  logic [SIZE_W-1:0]        img_size,
    output logic [NDRV-1:0]          drv_mounted,
    output logic [NDRV-1:0]          drv_ro,
    output logic [NDRV*SIZE_W-1:0]   drv_size
);
    typedef struct packed {
        logic              ro;
        logic [SIZE_W-1:0] size;
    } slot_s;

    for (genvar g = 0; g < NDRV; g++) begin : g_slot
        slot_s slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (img_mnt[g]) begin
                slot_d.ro   = img_ro;
                slot_d.size = img_size;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign drv_mounted[g]               = |slot_q.size;
        assign drv_ro[g]                    = slot_q.ro;
        assign drv_size[g*SIZE_W +: SIZE_W] = slot_q.size;
    end
endmodule

// File: rtl/vdx_sector_ram.sv
module vdx_sector_ram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Single process for both write ports; port A wins on a same-address clash.
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wdata;
        if (a_we) mem[a_addr] <= a_wdata;
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/vdx_req_fsm.sv
module vdx_req_fsm
    import vdx_pkg::*;
#(
    parameter int NDRV     = 2,
    parameter int DRV_W    = 1,
    parameter int BLK_CODE = 2,
    parameter int BUF_AW   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [DRV_W-1:0] req_drive,
    input  logic [LBA_W-1:0] req_lba,
    input  logic [CNT_W-1:0] req_cnt,
    input  logic [NDRV-1:0]  hst_ack,
    input  logic [NDRV-1:0]  drv_mounted,
    input  logic [NDRV-1:0]  drv_ro,
    output logic [NDRV-1:0]  hst_rd,
    output logic [NDRV-1:0]  hst_wr,
    output logic [LBA_W-1:0] hst_lba,
    output logic [CNT_W-1:0] hst_cnt,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             op_write,
    output logic             act_ack
);
    localparam logic [31:0] BUF_BYTES = 32'(1) << BUF_AW;
    localparam logic [31:0] LIMIT     = 32'(XFER_LIMIT);
    localparam int          LEN_SHIFT = BLK_CODE + BLK_BASE_SHIFT;

    typedef struct packed {
        xfer_state_e      st;
        logic             wr;
        logic [DRV_W-1:0] drv;
        logic [LBA_W-1:0] lba;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             err;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    logic            sel_in_range;
    logic            sel_mounted;
    logic            sel_ro;
    logic            ack_cur;
    logic [NDRV-1:0] cur_onehot;
    logic [31:0]     xfer_len;
    logic            len_ok;
    logic            req_ok;

    // Per-drive lookups written as loops so no index runs past NDRV.
    always_comb begin
        sel_in_range = 1'b0;
        sel_mounted  = 1'b0;
        sel_ro       = 1'b0;
        ack_cur      = 1'b0;
        cur_onehot   = '0;
        for (int i = 0; i < NDRV; i++) begin
            if (req_drive == DRV_W'(i)) begin
                sel_in_range = 1'b1;
                sel_mounted  = drv_mounted[i];
                sel_ro       = drv_ro[i];
            end
            if (fsm_q.drv == DRV_W'(i)) begin
                ack_cur       = hst_ack[i];
                cur_onehot[i] = 1'b1;
            end
        end
    end

    always_comb begin
        xfer_len = (32'(req_cnt) + 32'd1) << LEN_SHIFT;
        len_ok   = (xfer_len <= BUF_BYTES) && (xfer_len <= LIMIT);
        req_ok   = sel_in_range && sel_mounted && len_ok && !(req_write && sel_ro);
    end

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        fsm_d.err  = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (req_valid && !(|hst_ack)) begin
                    if (req_ok) begin
                        fsm_d.st  = ST_REQ;
                        fsm_d.wr  = req_write;
                        fsm_d.drv = req_drive;
                        fsm_d.lba = req_lba;
                        fsm_d.cnt = req_cnt;
                    end else begin
                        fsm_d.err = 1'b1;
                    end
                end
            end
            ST_REQ: begin
                if (ack_cur) fsm_d.st = ST_XFER;
            end
            ST_XFER: begin
                if (!ack_cur) begin
                    fsm_d.st   = ST_IDLE;
                    fsm_d.done = 1'b1;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= '{st: ST_IDLE, default: '0};
        else        fsm_q <= fsm_d;
    end

    assign hst_rd   = (fsm_q.st == ST_REQ && !fsm_q.wr) ? cur_onehot : '0;
    assign hst_wr   = (fsm_q.st == ST_REQ &&  fsm_q.wr) ? cur_onehot : '0;
    assign hst_lba  = fsm_q.lba;
    assign hst_cnt  = fsm_q.cnt;
    assign busy     = (fsm_q.st != ST_IDLE);
    assign done     = fsm_q.done;
    assign err      = fsm_q.err;
    assign op_write = fsm_q.wr;
    assign act_ack  = ack_cur;
endmodule

// File: rtl/vdx_xfer_client.sv
module vdx_xfer_client
    import vdx_pkg::*;
#(
    parameter int NDRV     = 2,
    parameter int BLK_CODE = 2,
    parameter int BUF_AW   = 9,
    parameter int DRV_W    = (NDRV > 1) ? $clog2(NDRV) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [DRV_W-1:0]       req_drive,
    input  logic [LBA_W-1:0]       req_lba,
    input  logic [CNT_W-1:0]       req_cnt,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    input  logic [BUF_AW-1:0]      core_addr,
    input  logic                   core_we,
    input  logic [7:0]             core_wdata,
    output logic [7:0]             core_rdata,
    output logic [NDRV-1:0]        hst_rd,
    output logic [NDRV-1:0]        hst_wr,
    output logic [LBA_W-1:0]       hst_lba,
    output logic [CNT_W-1:0]       hst_cnt,
    input  logic [NDRV-1:0]        hst_ack,
    input  logic [BUF_AW-1:0]      hst_addr,
    input  logic                   hst_wstb,
    input  logic [7:0]             hst_dout,
    output logic [7:0]             hst_din,
    input  logic [NDRV-1:0]        img_mnt,
    input  logic                   img_ro,
    input  logic [SIZE_W-1:0]      img_size,
    output logic [NDRV-1:0]        drv_mounted,
    output logic [NDRV-1:0]        drv_ro,
    output logic [NDRV*SIZE_W-1:0] drv_size
);
    logic op_write;
    logic act_ack;
    logic host_we;

    vdx_mount_track #(.NDRV(NDRV)) u_mount (
        .clk         (clk),
        .rst_n       (rst_n),
        .img_mnt     (img_mnt),
        .img_ro      (img_ro),
        .img_size    (img_size),
        .drv_mounted (drv_mounted),
        .drv_ro      (drv_ro),
        .drv_size    (drv_size)
    );

    vdx_req_fsm #(
        .NDRV     (NDRV),
        .DRV_W    (DRV_W),
        .BLK_CODE (BLK_CODE),
        .BUF_AW   (BUF_AW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_drive   (req_drive),
        .req_lba     (req_lba),
        .req_cnt     (req_cnt),
        .hst_ack     (hst_ack),
        .drv_mounted (drv_mounted),
        .drv_ro      (drv_ro),
        .hst_rd      (hst_rd),
        .hst_wr      (hst_wr),
        .hst_lba     (hst_lba),
        .hst_cnt     (hst_cnt),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .op_write    (op_write),
        .act_ack     (act_ack)
    );

    // Host bytes land in the buffer only inside a read window of the active drive.
    assign host_we = hst_wstb && busy && !op_write && act_ack;

    vdx_sector_ram #(.AW(BUF_AW), .DW(8)) u_ram (
        .clk     (clk),
        .a_addr  (hst_addr),
        .a_we    (host_we),
        .a_wdata (hst_dout),
        .a_rdata (hst_din),
        .b_addr  (core_addr),
        .b_we    (core_we),
        .b_wdata (core_wdata),
        .b_rdata (core_rdata)
    );
endmodule

// File: rtl/vdx_xfer_checker.sv
module vdx_xfer_checker #(
    parameter int NDRV = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic [NDRV-1:0] hst_rd,
    input logic [NDRV-1:0] hst_wr,
    input logic [NDRV-1:0] hst_ack,
    input logic [31:0]     hst_lba
);
    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hst_rd, hst_wr})); // R2

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hst_rd | hst_wr)) |-> busy); // R2

    AST_REQ_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|((hst_rd | hst_wr) & hst_ack)) |=> ((hst_rd | hst_wr) == '0)); // R3

    AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(|hst_ack, 2) && !$past(|hst_ack) && !busy)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (((hst_rd | hst_wr) == '0) && !busy)); // R8

    AST_LBA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(hst_lba)); // R9
endmodule

bind vdx_xfer_client vdx_xfer_checker #(.NDRV(NDRV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .hst_rd  (hst_rd),
    .hst_wr  (hst_wr),
    .hst_ack (hst_ack),
    .hst_lba (hst_lba)
);

// File: tb/tb_vdx_xfer_client.sv
module tb_vdx_xfer_client;
    localparam int CLK_PERIOD = 10;
    localparam int NDRV       = 2;
    localparam int DRV_W      = 1;
    localparam int BLK_CODE   = 0;
    localparam int BUF_AW     = 9;
    localparam int BLK_BYTES  = 128 << BLK_CODE;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0, req_write = 1'b0;
    logic [DRV_W-1:0]     req_drive = '0;
    logic [31:0]          req_lba = '0;
    logic [5:0]           req_cnt = '0;
    logic                 busy, done, err;
    logic [BUF_AW-1:0]    core_addr = '0;
    logic                 core_we = 1'b0;
    logic [7:0]           core_wdata = '0, core_rdata;
    logic [NDRV-1:0]      hst_rd, hst_wr;
    logic [31:0]          hst_lba;
    logic [5:0]           hst_cnt;
    logic [NDRV-1:0]      hst_ack = '0;
    logic [BUF_AW-1:0]    hst_addr = '0;
    logic                 hst_wstb = 1'b0;
    logic [7:0]           hst_dout = '0, hst_din;
    logic [NDRV-1:0]      img_mnt = '0;
    logic                 img_ro = 1'b0;
    logic [63:0]          img_size = '0;
    logic [NDRV-1:0]      drv_mounted, drv_ro;
    logic [NDRV*64-1:0]   drv_size;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vdx_xfer_client #(.NDRV(NDRV), .BLK_CODE(BLK_CODE), .BUF_AW(BUF_AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_drive(req_drive), .req_lba(req_lba), .req_cnt(req_cnt),
        .busy(busy), .done(done), .err(err),
        .core_addr(core_addr), .core_we(core_we), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_lba(hst_lba), .hst_cnt(hst_cnt),
        .hst_ack(hst_ack), .hst_addr(hst_addr), .hst_wstb(hst_wstb),
        .hst_dout(hst_dout), .hst_din(hst_din),
        .img_mnt(img_mnt), .img_ro(img_ro), .img_size(img_size),
        .drv_mounted(drv_mounted), .drv_ro(drv_ro), .drv_size(drv_size)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rpat(int d, int c, int a);
        return 8'((a * 7 + c * 13 + d * 29 + 5) & 255);
    endfunction

    function automatic logic [7:0] wpat(int d, int c, int a);
        return 8'((a * 11 + c * 3 + d * 17 + 1) & 255);
    endfunction

    task automatic mount(input int d, input bit ro, input logic [63:0] size);
        @(negedge clk);
        img_mnt = '0; img_mnt[d] = 1'b1; img_ro = ro; img_size = size;
        @(negedge clk);
        img_mnt = '0; img_ro = 1'b0; img_size = '0;
        chk(drv_size[d*64 +: 64] == size, "R7 size", drv_size[d*64 +: 64], size);
        chk(drv_ro[d] == ro, "R7 ro", 64'(drv_ro[d]), 64'(ro));
        chk(drv_mounted[d] == (size != 0), "R7 mounted", 64'(drv_mounted[d]), 64'(size != 0));
    endtask

    // Leaves the bench at the falling edge after the accepting edge.
    task automatic issue(input int d, input bit wr, input logic [31:0] lba, input int c);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_drive = DRV_W'(d);
        req_lba = lba; req_cnt = 6'(c);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_refused(input string tag);
        chk(err == 1'b1, {tag, " err"}, 64'(err), 64'd1);
        chk((hst_rd | hst_wr) == '0 && !busy, {tag, " no request"},
            64'({busy, hst_rd, hst_wr}), 64'd0);
        @(negedge clk);
        chk(err == 1'b0, {tag, " err single"}, 64'(err), 64'd0);
    endtask

    task automatic check_accept(input int d, input bit wr, input logic [31:0] lba, input int c);
        logic [NDRV-1:0] oh;
        oh = '0; oh[d] = 1'b1;
        chk(busy && hst_rd == (wr ? '0 : oh) && hst_wr == (wr ? oh : '0),
            "R2 request line", 64'({busy, hst_rd, hst_wr}), 64'({1'b1, wr ? 2'b00 : oh, wr ? oh : 2'b00}));
        chk(hst_lba == lba && hst_cnt == 6'(c), "R2 lba/cnt",
            {hst_lba, 26'd0, hst_cnt}, {lba, 26'd0, 6'(c)});
    endtask

    task automatic finish_window();
        hst_wstb = 1'b0; hst_ack = '0;
        @(negedge clk);
        chk(done == 1'b1 && !busy, "R4 done on ack fall", 64'({done, busy}), 64'b10);
        @(negedge clk);
        chk(done == 1'b0, "R4 done single cycle", 64'(done), 64'd0);
    endtask

    task automatic read_xfer(input int d, input int c);
        int n = (c + 1) * BLK_BYTES;
        int mism = 0;
        logic [7:0] first_act = '0, first_exp = '0;
        logic [31:0] lba = 32'(1000 + d * 64 + c);
        issue(d, 1'b0, lba, c);
        check_accept(d, 1'b0, lba, c);
        @(negedge clk);
        chk(hst_rd[d] == 1'b1, "R3 request held until ack", 64'(hst_rd), 64'(1 << d));
        hst_ack[d] = 1'b1;
        @(negedge clk);
        chk((hst_rd | hst_wr) == '0 && busy, "R3 request drop", 64'({busy, hst_rd}), 64'b100);
        for (int a = 0; a < n; a++) begin
            hst_addr = BUF_AW'(a); hst_dout = rpat(d, c, a); hst_wstb = 1'b1;
            @(negedge clk);
        end
        finish_window();
        for (int a = 0; a <= n; a++) begin
            if (a > 0 && core_rdata != rpat(d, c, a - 1)) begin
                if (mism == 0) begin first_act = core_rdata; first_exp = rpat(d, c, a - 1); end
                mism++;
            end
            if (a < n) core_addr = BUF_AW'(a);
            @(negedge clk);
        end
        chk(mism == 0, "R5 read block contents", 64'(first_act), 64'(first_exp));
    endtask

    task automatic write_xfer(input int d, input int c);
        int n = (c + 1) * BLK_BYTES;
        int mism = 0, rmism = 0;
        logic [7:0] fa = '0, fe = '0;
        logic [31:0] lba = 32'(5000 + c);
        for (int a = 0; a < n; a++) begin
            @(negedge clk);
            core_we = 1'b1; core_addr = BUF_AW'(a); core_wdata = wpat(d, c, a);
        end
        @(negedge clk);
        core_we = 1'b0;
        issue(d, 1'b1, lba, c);
        check_accept(d, 1'b1, lba, c);
        hst_ack[d] = 1'b1;
        @(negedge clk);
        chk((hst_rd | hst_wr) == '0, "R3 write request drop", 64'(hst_wr), 64'd0);
        for (int a = 0; a <= n; a++) begin
            if (a > 0 && hst_din != wpat(d, c, a - 1)) begin
                if (mism == 0) begin fa = hst_din; fe = wpat(d, c, a - 1); end
                mism++;
            end
            if (a < n) begin
                hst_addr = BUF_AW'(a); hst_dout = ~wpat(d, c, a); hst_wstb = 1'b1;
            end
            @(negedge clk);
        end
        finish_window();
        chk(mism == 0, "R6 hst_din stream", 64'(fa), 64'(fe));
        for (int a = 0; a <= n; a++) begin
            if (a > 0 && core_rdata != wpat(d, c, a - 1)) rmism++;
            if (a < n) core_addr = BUF_AW'(a);
            @(negedge clk);
        end
        chk(rmism == 0, "R6 strobe ignored during write", 64'(rmism), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && hst_rd == '0 && hst_wr == '0 && drv_mounted == '0,
            "reset state", 64'({busy, done, err, hst_rd, hst_wr, drv_mounted}), 64'd0);

        issue(0, 1'b0, 32'd7, 0);
        expect_refused("R8 unmounted");

        mount(0, 1'b0, 64'h1_0000_0000);
        mount(1, 1'b1, 64'd4096);

        for (int d = 0; d < NDRV; d++)
            for (int c = 0; c < 4; c++) read_xfer(d, c);   // R1 lengths 128..512

        for (int c = 0; c < 4; c++) write_xfer(0, c);

        issue(1, 1'b1, 32'd3, 0);
        expect_refused("R8 write to read-only");

        issue(0, 1'b0, 32'd3, 4);                          // 640 bytes > 512
        expect_refused("R1 too long");
        issue(0, 1'b0, 32'd3, 63);
        expect_refused("R1 limit");

        // R9: request during an open window is ignored.
        issue(0, 1'b0, 32'h55, 0);
        check_accept(0, 1'b0, 32'h55, 0);
        hst_ack[0] = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_drive = 1'b0; req_lba = 32'hDEAD; req_cnt = 6'd1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(hst_lba == 32'h55 && hst_cnt == 6'd0 && hst_wr == '0 && !err,
            "R9 ignored while busy", 64'({hst_lba, hst_cnt, hst_wr, err}), 64'({32'h55, 6'd0, 2'b00, 1'b0}));
        finish_window();

        // R9: idle but a stray acknowledge is high.
        @(negedge clk);
        hst_ack[1] = 1'b1;
        issue(0, 1'b0, 32'h99, 0);
        chk(!busy && hst_rd == '0 && !err && hst_lba == 32'h55, "R9 ignored while ack high",
            64'({busy, hst_rd, err}), 64'd0);
        hst_ack = '0;

        mount(0, 1'b0, 64'd0);
        issue(0, 1'b0, 32'd1, 0);
        expect_refused("R8 after unmount R7");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule